// File: doc/BRIEF.md
# Inbound Address Translation Unit

This block translates the 64-bit address of a request that arrives from the PCIe side into a 64-bit address in the AXI system space. It holds a fixed set of inbound regions. Each region has a PCI base address and a one-hot size select. Each region is cut into an equal, power-of-two number of windows, and every window has its own AXI base address and valid flag. Software programs all of these through a 32-bit word-addressed register port. Register reads are combinational.

The request port takes a PCI address with a valid strobe. One cycle later it returns the translated AXI address together with a miss flag. A request hits when an enabled region covers the address and the window that the address selects is valid. The result is that window's AXI base OR-ed with the offset inside the window. When more than one region covers an address, the lowest-numbered region wins.

Top module: `iatu_top`

## Requirements
- R1: After reset `rspValid` is 0 and every register word reads as zero.
- R2: The low range word keeps bits [8:0] (size select) and bits [31:20] (PCI base). The low window word keeps bit 0 (valid) and bits [31:19] (AXI base). All other bits of these words read as zero. The high words of both kinds keep all 32 bits.
- R3: Word address = region*8 + slot. Slot 0 is the low range word and slot 1 the high range word. Slots 2/3 hold window 0 low/high and slots 4/5 hold window 1 low/high. Slots 6/7 and regions 5 and above read as zero, and writes to them change no register.
- R4: A region with no size-select bit set never matches.
- R5: Size-select bit n gives a region size of 2^(20+n) bytes for n = 0..8. When several bits are set, the lowest set bit decides.
- R6: A region of size S is split into two windows of size S/2. Address bit log2(S)-1 picks the window. A hit returns that window's AXI base OR-ed with the address bits below log2(S)-1.
- R7: A request that lands in a window whose valid bit is 0 returns miss = 1 and address 0.
- R8: A request that no enabled region covers returns miss = 1 and address 0.
- R9: When several regions cover the address, the lowest-numbered region gives the result.
- R10: Each cycle with `reqValid` high gives a cycle with `rspValid` high exactly one cycle later. `rspValid` is low in any other cycle.
- R11: A register write takes effect for a request issued in the next cycle. A request issued in the same cycle as the write sees the old contents.
- R12: On a hit, address bits [18:0] pass from request to result unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 6 | Register word address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for `regAddr` (combinational) |
| reqValid | input | 1 | Translation request strobe |
| reqAddr | input | 64 | PCI-side request address |
| rspValid | output | 1 | Translation result valid |
| rspMiss | output | 1 | 1 when no valid window covered the request |
| rspAddr | output | 64 | Translated AXI address, zero on a miss |

## Verification
The assertions assume that software programs AXI window bases with zero bits below the minimum window size. The register masks enforce this, so the pass-through check on the offset depends only on request timing. The assertions also assume that `reqValid` is low while reset is held. The bench drives the strobes from reset onward and always programs region bases aligned to the selected size. It sweeps all nine sizes, offsets at both window edges, and overlapping regions, and computes each expected address as base plus offset.

// File: rtl/iatu_pkg.sv
package iatu_pkg;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_RANGE_LO,
    RD_RANGE_HI,
    RD_MAP_LO,
    RD_MAP_HI
  } iatuRdSel_e;

  typedef struct packed {
    logic wrRangeLo;
    logic wrRangeHi;
    logic wrMapLo;
    logic wrMapHi;
    logic reqLoad;
  } iatuStrobes_t;

endpackage

// File: rtl/iatu_ctrl.sv
module iatu_ctrl
  import iatu_pkg::*;
#(
  parameter int NUM_REGIONS = 5,
  parameter int NUM_WIN     = 2,
  parameter int REG_W       = 3,
  parameter int SLOT_W      = 3,
  parameter int WIDX_W      = 1,
  parameter int ADDR_W      = 6
) (
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              reqValid,
  output iatuStrobes_t      strobes,
  output iatuRdSel_e        rdSel,
  output logic [REG_W-1:0]  regionIdx,
  output logic [WIDX_W-1:0] windowIdx
);

  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] mapSlot;
  logic [SLOT_W-1:0] winNum;

  always_comb begin
    regionIdx = regAddr[ADDR_W-1:SLOT_W];
    slot      = regAddr[SLOT_W-1:0];
    mapSlot   = slot - SLOT_W'(2);
    winNum    = mapSlot >> 1;
    windowIdx = winNum[WIDX_W-1:0];

    if (int'(regionIdx) >= NUM_REGIONS) begin
      rdSel = RD_NONE;
    end else if (slot == SLOT_W'(0)) begin
      rdSel = RD_RANGE_LO;
    end else if (slot == SLOT_W'(1)) begin
      rdSel = RD_RANGE_HI;
    end else if (int'(winNum) < NUM_WIN) begin
      rdSel = mapSlot[0] ? RD_MAP_HI : RD_MAP_LO;
    end else begin
      rdSel = RD_NONE;
    end

    strobes.wrRangeLo = regWrEn && (rdSel == RD_RANGE_LO);
    strobes.wrRangeHi = regWrEn && (rdSel == RD_RANGE_HI);
    strobes.wrMapLo   = regWrEn && (rdSel == RD_MAP_LO);
    strobes.wrMapHi   = regWrEn && (rdSel == RD_MAP_HI);
    strobes.reqLoad   = reqValid;
  end

endmodule

// File: rtl/iatu_datapath.sv
module iatu_datapath
  import iatu_pkg::*;
#(
  parameter int NUM_REGIONS   = 5,
  parameter int NUM_SIZES     = 9,
  parameter int MIN_SIZE_LOG2 = 20,
  parameter int WIN_LOG2      = 1,
  parameter int NUM_WIN       = 2,
  parameter int REG_W         = 3,
  parameter int WIDX_W        = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  iatuStrobes_t      strobes,
  input  iatuRdSel_e        rdSel,
  input  logic [REG_W-1:0]  regionIdx,
  input  logic [WIDX_W-1:0] windowIdx,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  input  logic [63:0]       reqAddr,
  output logic              rspValid,
  output logic              rspMiss,
  output logic [63:0]       rspAddr
);

  localparam int          WMIN     = MIN_SIZE_LOG2 - WIN_LOG2;
  localparam logic [31:0] RLO_MASK = (32'hFFFF_FFFF << MIN_SIZE_LOG2) | ((32'd1 << NUM_SIZES) - 32'd1);
  localparam logic [31:0] MLO_MASK = (32'hFFFF_FFFF << WMIN) | 32'd1;

  logic [31:0] rangeLo [NUM_REGIONS];
  logic [31:0] rangeHi [NUM_REGIONS];
  logic [31:0] mapLo   [NUM_REGIONS][NUM_WIN];
  logic [31:0] mapHi   [NUM_REGIONS][NUM_WIN];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REGIONS; r++) begin
        rangeLo[r] <= '0;
        rangeHi[r] <= '0;
        for (int w = 0; w < NUM_WIN; w++) begin
          mapLo[r][w] <= '0;
          mapHi[r][w] <= '0;
        end
      end
    end else begin
      for (int r = 0; r < NUM_REGIONS; r++) begin
        if (regionIdx == REG_W'(r)) begin
          if (strobes.wrRangeLo) rangeLo[r] <= wrData & RLO_MASK;
          if (strobes.wrRangeHi) rangeHi[r] <= wrData;
          for (int w = 0; w < NUM_WIN; w++) begin
            if (windowIdx == WIDX_W'(w)) begin
              if (strobes.wrMapLo) mapLo[r][w] <= wrData & MLO_MASK;
              if (strobes.wrMapHi) mapHi[r][w] <= wrData;
            end
          end
        end
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int r = 0; r < NUM_REGIONS; r++) begin
      if (regionIdx == REG_W'(r)) begin
        case (rdSel)
          RD_RANGE_LO: rdData = rangeLo[r];
          RD_RANGE_HI: rdData = rangeHi[r];
          RD_MAP_LO, RD_MAP_HI: begin
            for (int w = 0; w < NUM_WIN; w++) begin
              if (windowIdx == WIDX_W'(w))
                rdData = (rdSel == RD_MAP_LO) ? mapLo[r][w] : mapHi[r][w];
            end
          end
          default: rdData = '0;
        endcase
      end
    end
  end

  logic [NUM_REGIONS-1:0]       regHit;
  logic [NUM_REGIONS-1:0]       winValid;
  logic [NUM_REGIONS-1:0][63:0] xlatAll;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    logic [NUM_SIZES-1:0] sizeSel;
    logic [NUM_SIZES-1:0] firstOne;
    logic [63:0]          regMask;
    logic [63:0]          winMask;
    logic [63:0]          base;
    logic [63:0]          axiBase;
    logic [WIDX_W-1:0]    win;
    logic                 hitL;

    always_comb begin
      sizeSel  = rangeLo[r][NUM_SIZES-1:0];
      firstOne = sizeSel & (~sizeSel + NUM_SIZES'(1));
      regMask  = '0;
      winMask  = '0;
      win      = '0;
      for (int n = 0; n < NUM_SIZES; n++) begin
        if (firstOne[n]) begin
          regMask = ~((64'd1 << (MIN_SIZE_LOG2 + n)) - 64'd1);
          winMask = (64'd1 << (MIN_SIZE_LOG2 + n - WIN_LOG2)) - 64'd1;
          win     = reqAddr[MIN_SIZE_LOG2 + n - WIN_LOG2 +: WIDX_W] & WIDX_W'(NUM_WIN - 1);
        end
      end
      base    = {rangeHi[r], rangeLo[r]};
      axiBase = {mapHi[r][win], mapLo[r][win] & ~32'd1};
      hitL    = (|sizeSel) && ((reqAddr & regMask) == (base & regMask));
    end

    assign regHit[r]   = hitL;
    assign winValid[r] = mapLo[r][win][0];
    assign xlatAll[r]  = axiBase | (reqAddr & winMask);
  end

  logic        anyHit;
  logic        selValid;
  logic [63:0] selAddr;

  always_comb begin
    anyHit   = 1'b0;
    selValid = 1'b0;
    selAddr  = '0;
    for (int r = NUM_REGIONS - 1; r >= 0; r--) begin
      if (regHit[r]) begin
        anyHit   = 1'b1;
        selValid = winValid[r];
        selAddr  = xlatAll[r];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspMiss  <= 1'b0;
      rspAddr  <= '0;
    end else begin
      rspValid <= strobes.reqLoad;
      if (strobes.reqLoad) begin
        rspMiss <= !(anyHit && selValid);
        rspAddr <= (anyHit && selValid) ? selAddr : '0;
      end
    end
  end

endmodule

// File: rtl/iatu_top.sv
module iatu_top
  import iatu_pkg::*;
#(
  parameter  int NUM_REGIONS   = 5,
  parameter  int NUM_SIZES     = 9,
  parameter  int MIN_SIZE_LOG2 = 20,
  parameter  int WIN_LOG2      = 1,
  localparam int NUM_WIN       = 1 << WIN_LOG2,
  localparam int SLOT_W        = $clog2(2 + 2 * NUM_WIN),
  localparam int REG_W         = $clog2(NUM_REGIONS),
  localparam int ADDR_W        = REG_W + SLOT_W,
  localparam int WIDX_W        = (WIN_LOG2 > 0) ? WIN_LOG2 : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              reqValid,
  input  logic [63:0]       reqAddr,
  output logic              rspValid,
  output logic              rspMiss,
  output logic [63:0]       rspAddr
);

  iatuStrobes_t      strobes;
  iatuRdSel_e        rdSel;
  logic [REG_W-1:0]  regionIdx;
  logic [WIDX_W-1:0] windowIdx;

  iatu_ctrl #(
    .NUM_REGIONS(NUM_REGIONS), .NUM_WIN(NUM_WIN), .REG_W(REG_W),
    .SLOT_W(SLOT_W), .WIDX_W(WIDX_W), .ADDR_W(ADDR_W)
  ) u_ctrl (
    .regWrEn(regWrEn), .regAddr(regAddr), .reqValid(reqValid),
    .strobes(strobes), .rdSel(rdSel), .regionIdx(regionIdx), .windowIdx(windowIdx)
  );

  iatu_datapath #(
    .NUM_REGIONS(NUM_REGIONS), .NUM_SIZES(NUM_SIZES), .MIN_SIZE_LOG2(MIN_SIZE_LOG2),
    .WIN_LOG2(WIN_LOG2), .NUM_WIN(NUM_WIN), .REG_W(REG_W), .WIDX_W(WIDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdSel(rdSel),
    .regionIdx(regionIdx), .windowIdx(windowIdx), .wrData(regWrData),
    .rdData(regRdData), .reqAddr(reqAddr), .rspValid(rspValid),
    .rspMiss(rspMiss), .rspAddr(rspAddr)
  );

endmodule

// File: rtl/iatu_checker.sv
module iatu_checker #(
  parameter int NUM_REGIONS = 5,
  parameter int SLOT_W      = 3,
  parameter int ADDR_W      = 6,
  parameter int WMIN        = 19
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regRdData,
  input logic              reqValid,
  input logic [63:0]       reqAddr,
  input logic              rspValid,
  input logic              rspMiss,
  input logic [63:0]       rspAddr
);

  p_rsp_follows_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  p_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  p_miss_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspMiss) |-> (rspAddr == 64'd0));

  p_offset_pass_r12: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (rspMiss || (rspAddr[WMIN-1:0] == $past(reqAddr[WMIN-1:0]))));

  p_unmapped_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    (int'(regAddr[ADDR_W-1:SLOT_W]) >= NUM_REGIONS) |-> (regRdData == 32'd0));

endmodule

bind iatu_top iatu_checker #(
  .NUM_REGIONS(NUM_REGIONS), .SLOT_W(SLOT_W), .ADDR_W(ADDR_W),
  .WMIN(MIN_SIZE_LOG2 - WIN_LOG2)
) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regRdData(regRdData),
  .reqValid(reqValid), .reqAddr(reqAddr), .rspValid(rspValid),
  .rspMiss(rspMiss), .rspAddr(rspAddr)
);

// File: tb/iatu_top_bench.sv
module iatu_top_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        reqValid = 1'b0;
  logic [63:0] reqAddr = '0;
  logic        rspValid;
  logic        rspMiss;
  logic [63:0] rspAddr;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  iatu_top u_iatu_top (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .reqValid(reqValid),
    .reqAddr(reqAddr), .rspValid(rspValid), .rspMiss(rspMiss), .rspAddr(rspAddr)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int region, input int slot, input logic [31:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 6'(region * 8 + slot); regWrData = data;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(input int a, input logic [31:0] exp, input string req);
    @(negedge clk);
    regAddr = 6'(a);
    #1;
    chk(regRdData == exp, req, 64'(regRdData), 64'(exp));
  endtask

  task automatic setRegion(input int r, input logic [63:0] base, input logic [31:0] sizeBits);
    wr(r, 1, base[63:32]);
    wr(r, 0, base[31:0] | sizeBits);
  endtask

  task automatic setWin(input int r, input int k, input logic [63:0] axi, input bit v);
    wr(r, 3 + 2 * k, axi[63:32]);
    wr(r, 2 + 2 * k, axi[31:0] | 32'(v));
  endtask

  task automatic reqChk(input logic [63:0] a, input bit expMiss, input logic [63:0] exp, input string req);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a;
    @(posedge clk); #1;
    reqValid = 1'b0;
    @(negedge clk);
    chk(rspValid && (rspMiss == expMiss) && (rspAddr == exp), req, rspAddr, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] bRegion, a0, a1, ws, off, expA;
    repeat (3) @(posedge clk);
    #1;
    chk(!rspValid, "R1 rspValid in reset", 64'(rspValid), 64'd0);
    rstN = 1'b1;

    // R1 / R3: every word (incl. out-of-range regions and spare slots) reads zero
    for (int a = 0; a < 64; a++) rdChk(a, 32'd0, (a >= 40) ? "R3 unmapped read" : "R1 reset read");

    // R2: masking of stored bits
    wr(0, 0, 32'hFFFF_FFFF);
    wr(0, 1, 32'hFFFF_FFFF);
    wr(0, 2, 32'hFFFF_FFFF);
    wr(0, 5, 32'hDEAD_BEEF);
    rdChk(0, 32'hFFF0_01FF, "R2 range lo mask");
    rdChk(1, 32'hFFFF_FFFF, "R2 range hi");
    rdChk(2, 32'hFFF8_0001, "R2 map lo mask");
    rdChk(5, 32'hDEAD_BEEF, "R2 map hi window1");
    // R3: spare slot and out-of-range region writes are ignored
    wr(0, 6, 32'h1234_5678);
    wr(5, 0, 32'h1234_5678);
    rdChk(6, 32'd0, "R3 spare slot write ignored");
    rdChk(40, 32'd0, "R3 region5 write ignored");
    rdChk(0, 32'hFFF0_01FF, "R3 region0 untouched");
    rdChk(8, 32'd0, "R3 region1 untouched");
    wr(0, 0, 32'd0); wr(0, 1, 32'd0); wr(0, 2, 32'd0); wr(0, 5, 32'd0);

    // R5 / R6 / R8: sweep all sizes on region 1
    bRegion = 64'h0000_0012_0000_0000;
    a0 = 64'h0000_0A00_0000_0000;
    for (int n = 0; n < 9; n++) begin
      ws = 64'd1 << (19 + n);
      a1 = (n % 2 == 0) ? a0 + ws : 64'h0000_0B00_0000_0000;
      setRegion(1, bRegion, 32'd1 << n);
      setWin(1, 0, a0, 1'b1);
      setWin(1, 1, a1, 1'b1);
      for (int t = 0; t < 5; t++) begin
        case (t)
          0: off = 64'd0;
          1: off = ws - 1;
          2: off = ws;
          3: off = 2 * ws - 1;
          default: off = (64'h5A5A5 * 64'(n + 1)) % (2 * ws);
        endcase
        expA = (off < ws) ? a0 + off : a1 + (off - ws);
        reqChk(bRegion + off, 1'b0, expA, "R6 window translate");
      end
      reqChk(bRegion + 2 * ws, 1'b1, 64'd0, "R5 above region size");
      reqChk(bRegion - 1, 1'b1, 64'd0, "R8 below base");
    end

    // R5: lowest set size bit decides (bits 1 and 2 set -> 2 MB)
    setRegion(1, bRegion, 32'b110);
    setWin(1, 0, a0, 1'b1);
    setWin(1, 1, a0 + 64'h10_0000, 1'b1);
    reqChk(bRegion + 64'h1F_FFFF, 1'b0, a0 + 64'h1F_FFFF, "R5 lowest bit top");
    reqChk(bRegion + 64'h20_0000, 1'b1, 64'd0, "R5 lowest bit beyond");

    // R7: invalid window gives miss, other window still hits
    setRegion(1, bRegion, 32'd1);
    setWin(1, 1, a0 + 64'h8_0000, 1'b0);
    reqChk(bRegion + 64'h8_0005, 1'b1, 64'd0, "R7 invalid window");
    reqChk(bRegion + 64'h5, 1'b0, a0 + 64'h5, "R7 valid window");

    // R4: no size bit means never matches
    setRegion(1, bRegion, 32'd0);
    reqChk(bRegion + 64'h5, 1'b1, 64'd0, "R4 disabled region");

    // R8: far address
    reqChk(64'hFFFF_0000_0000_0000, 1'b1, 64'd0, "R8 no region");

    // R9: overlap between region 0 (1 MB) and region 3 (4 MB)
    setRegion(0, 64'h40_0000_0000, 32'd1);
    setWin(0, 0, 64'h1000_0000, 1'b1);
    setWin(0, 1, 64'h1008_0000, 1'b1);
    setRegion(3, 64'h40_0000_0000, 32'd4);
    setWin(3, 0, 64'h2000_0000, 1'b1);
    setWin(3, 1, 64'h2020_0000, 1'b1);
    reqChk(64'h40_0000_0100, 1'b0, 64'h1000_0100, "R9 lowest region wins");
    reqChk(64'h40_0030_0000, 1'b0, 64'h2030_0000, "R9 outside region0 falls to region3");
    wr(0, 0, 32'd0);
    reqChk(64'h40_0000_0100, 1'b0, 64'h2000_0100, "R9 region3 after region0 off");
    wr(3, 0, 32'd0);

    // R11 / R10: same-cycle write sees old contents, next request sees new
    wr(2, 1, 32'h7);
    setWin(2, 0, 64'h3000_0000, 1'b1);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 6'(16); regWrData = 32'd1;
    reqValid = 1'b1; reqAddr = 64'h7_0000_0010;
    @(posedge clk); #1;
    regWrEn = 1'b0;
    @(negedge clk);
    chk(rspValid && rspMiss && rspAddr == 64'd0, "R11 same-cycle request sees old", rspAddr, 64'd0);
    @(posedge clk); #1;
    reqValid = 1'b0;
    @(negedge clk);
    chk(rspValid && !rspMiss && rspAddr == 64'h3000_0010, "R11 next-cycle request sees new", rspAddr, 64'h3000_0010);
    @(negedge clk);
    chk(!rspValid, "R10 rspValid drops after idle", 64'(rspValid), 64'd0);
    // R12: low bits unchanged on a hit
    reqChk(64'h7_0007_ABCD, 1'b0, 64'h3007_ABCD, "R12 offset pass-through");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule